// File: doc/BRIEF.md
# Data Address Generator with Circular Buffering

This block forms the data-memory address for each load or store and keeps the pointer state between accesses. It holds four 16-bit pointers. On an indirect access one pointer drives the address bus in the same cycle. That pointer is then post-modified at the closing clock edge by one of three fixed steps or by one of two signed user increments.

A pair of boundary registers (first and last) turns the pointers into circular-buffer walkers. A pointer that sits on the last address is reloaded with the first address instead of being stepped, at no cost in cycles. A direct mode joins the upper bits of a base register with a 5-bit offset taken from the instruction. Every address is decoded into one-hot region enables for the data memory banks.

Software loads the pointers and configuration registers through a single write port. The instruction decoder drives the access fields each cycle.

Top module: `dag_top`

## Requirements
- R1: After synchronous reset, all four pointers and the first, last, base and both increment registers read as zero.
- R2: A write with `wr_sel` 0..3 loads pointer 0..3 at the next clock edge. Codes 4, 5, 6, 7 and 8 load first, last, increment A, increment B and base respectively.
- R3: During an indirect access (`acc_en`=1, `acc_direct`=0), `addr_out` equals the selected pointer's value before modification, in the same cycle. The pointer takes its modified value at the next edge. With `acc_en`=0, `addr_out` is zero.
- R4: Step codes 1, 2 and 3 add +1, -1 and +2 to the pointer.
- R5: Step codes 4 and 5 add increment A and increment B, each treated as a signed 16-bit value.
- R6: If a moving step is applied to a pointer that equals the last register, and the last register is nonzero, the pointer becomes the first register's value instead.
- R7: If the last register is zero, no wrap occurs. The pointer is stepped with ordinary 16-bit two's-complement arithmetic, so 0xFFFF + 1 gives 0x0000.
- R8: In direct mode, `addr_out` is {base[15:5], `dir_off`} and no pointer changes, whatever the pointer and step fields hold.
- R9: `bank_en[k]` is 1 only during an access whose address bits [15:11] equal k (k = 0..3). Addresses from 0x2000 upward, and idle cycles, raise no enable.
- R10: Step codes 0, 6 and 7 leave the pointer unchanged. A write to the same pointer in the cycle it is post-modified takes priority over the modification.
- R11: Writes with `wr_sel` 9..15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 16 | Write data |
| acc_en | input | 1 | Memory access this cycle |
| acc_direct | input | 1 | 1 selects direct mode, 0 selects indirect |
| ptr_sel | input | 2 | Pointer used by an indirect access |
| step_sel | input | 3 | Post-modification step code |
| dir_off | input | 5 | Low address bits for direct mode |
| addr_out | output | 16 | Data memory address |
| bank_en | output | 4 | One-hot memory region enables |

## Verification
Two functions can land on the same pointer in one cycle: a register write and the post-modification of an access. The bench provokes this by writing pointer 0 while stepping it by +1 in the same vector. It then judges the outcome by reading the pointer back with a hold step on the next access, where the written value must appear rather than the stepped one. The wrap decision meets the boundary writes in the same way: the last register is cleared just before a pointer reaches 0x0000, and the bench confirms that the step yields 1 instead of a reload from the first register.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int ADDR_W     = 16;
    localparam int NUM_PTR    = 4;
    localparam int PTR_IW     = $clog2(NUM_PTR);
    localparam int OFF_W      = 5;
    localparam int BANK_SHIFT = 11;
    localparam int NUM_BANK   = 4;
    localparam int SEL_W      = 4;

    typedef enum logic [2:0] {
        STEP_HOLD  = 3'd0,
        STEP_INC1  = 3'd1,
        STEP_DEC1  = 3'd2,
        STEP_INC2  = 3'd3,
        STEP_USR_A = 3'd4,
        STEP_USR_B = 3'd5,
        STEP_RSV6  = 3'd6,
        STEP_RSV7  = 3'd7
    } step_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_FIRST = 4'd4,
        SEL_LAST  = 4'd5,
        SEL_USR_A = 4'd6,
        SEL_USR_B = 4'd7,
        SEL_BASE  = 4'd8
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] usr_a;
        logic [ADDR_W-1:0] usr_b;
        logic [ADDR_W-1:0] base;
    } cfg_t;

    function automatic logic step_moves(input step_e s);
        return (s == STEP_INC1) || (s == STEP_DEC1) || (s == STEP_INC2) ||
               (s == STEP_USR_A) || (s == STEP_USR_B);
    endfunction

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int N  = NUM_PTR,
    parameter int AW = ADDR_W,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [AW-1:0]        wr_data,
    input  logic                 upd_en,
    input  logic [IW-1:0]        upd_idx,
    input  logic [AW-1:0]        upd_val,
    output logic [N-1:0][AW-1:0] ptr_q
);

    for (genvar i = 0; i < N; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                ptr_q[i] <= wr_data;
            end else if (upd_en && upd_idx == IW'(i)) begin
                ptr_q[i] <= upd_val;
            end
        end
    end

    // R10: a write to a pointer beats a post-modify of that pointer
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/dag_modify.sv
module dag_modify
    import dag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  step_e         step,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] usr_a,
    input  logic [AW-1:0] usr_b,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    output logic          moves,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] delta;
    logic          at_last;

    always_comb begin
        unique case (step)
            STEP_INC1:  delta = AW'(1);
            STEP_DEC1:  delta = '1;
            STEP_INC2:  delta = AW'(2);
            STEP_USR_A: delta = usr_a;
            STEP_USR_B: delta = usr_b;
            default:    delta = '0;
        endcase
    end

    assign moves   = step_moves(step);
    assign at_last = (cur == last) && (last != '0);
    assign nxt     = at_last ? first : cur + delta;

endmodule

// File: rtl/dag_bank_dec.sv
module dag_bank_dec
    import dag_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NB    = NUM_BANK,
    parameter int SHIFT = BANK_SHIFT,
    localparam int RW   = AW - SHIFT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [NB-1:0] bank_en
);

    logic [RW-1:0] region;
    assign region = addr[AW-1:SHIFT];

    for (genvar k = 0; k < NB; k++) begin : g_bank
        assign bank_en[k] = en && (region == RW'(k));
    end

    // R9: at most one region enable at a time
    a_r9_bank_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_en));

endmodule

// File: rtl/dag_top.sv
module dag_top
    import dag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NP = NUM_PTR,
    parameter int OW = OFF_W,
    parameter int NB = NUM_BANK,
    localparam int IW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [15:0]   wr_data,
    input  logic          acc_en,
    input  logic          acc_direct,
    input  logic [1:0]    ptr_sel,
    input  logic [2:0]    step_sel,
    input  logic [4:0]    dir_off,
    output logic [15:0]   addr_out,
    output logic [3:0]    bank_en
);

    cfg_t                  cfg_q;
    logic [NP-1:0][AW-1:0] ptr_q;
    logic [AW-1:0]         sel_ptr;
    logic [AW-1:0]         nxt_ptr;
    logic                  moves;
    logic                  upd_en;
    logic                  ptr_wr;
    step_e                 step;

    assign step    = step_e'(step_sel);
    assign sel_ptr = ptr_q[ptr_sel];
    assign ptr_wr  = wr_en && (wr_sel < SEL_W'(NP));
    assign upd_en  = acc_en && !acc_direct && moves;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_FIRST: cfg_q.first <= wr_data;
                SEL_LAST:  cfg_q.last  <= wr_data;
                SEL_USR_A: cfg_q.usr_a <= wr_data;
                SEL_USR_B: cfg_q.usr_b <= wr_data;
                SEL_BASE:  cfg_q.base  <= wr_data;
                default: ;
            endcase
        end
    end

    dag_regfile #(.N(NP), .AW(AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ptr_wr),
        .wr_idx  (wr_sel[IW-1:0]),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_idx (ptr_sel),
        .upd_val (nxt_ptr),
        .ptr_q   (ptr_q)
    );

    dag_modify #(.AW(AW)) u_mod (
        .step  (step),
        .cur   (sel_ptr),
        .usr_a (cfg_q.usr_a),
        .usr_b (cfg_q.usr_b),
        .first (cfg_q.first),
        .last  (cfg_q.last),
        .moves (moves),
        .nxt   (nxt_ptr)
    );

    always_comb begin
        if (!acc_en)
            addr_out = '0;
        else if (acc_direct)
            addr_out = {cfg_q.base[AW-1:OW], dir_off};
        else
            addr_out = sel_ptr;
    end

    dag_bank_dec #(.AW(AW), .NB(NB), .SHIFT(BANK_SHIFT)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .en      (acc_en),
        .addr    (addr_out),
        .bank_en (bank_en)
    );

    // R9: no enable on an idle cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> bank_en == '0);

    // R8: direct access leaves every pointer alone
    a_r8_direct_hold: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_direct && !wr_en) |=> $stable(ptr_q));

    // R6: stepping from the last address reloads the first address
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_direct && step_moves(step) && !ptr_wr &&
         sel_ptr == cfg_q.last && cfg_q.last != '0)
        |=> ptr_q[$past(ptr_sel)] == $past(cfg_q.first));

    // R3: address equals selected pointer on indirect access
    a_r3_indirect_addr: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_direct) |-> addr_out == ptr_q[ptr_sel]);

endmodule

// File: tb/dag_top_tb_top.sv
module dag_top_tb_top;

    typedef struct packed {
        logic        wr;
        logic [3:0]  wsel;
        logic [15:0] wdata;
        logic        acc;
        logic        dir;
        logic [1:0]  psel;
        logic [2:0]  step;
        logic [4:0]  off;
        logic [15:0] ea;
        logic [3:0]  eb;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t vw(logic [3:0] s, logic [15:0] d, logic [7:0] r);
        vec_t v = '0;
        v.wr = 1'b1; v.wsel = s; v.wdata = d; v.req = r;
        return v;
    endfunction

    function automatic vec_t va(logic [1:0] p, logic [2:0] st, logic [15:0] ea,
                                logic [3:0] eb, logic [7:0] r);
        vec_t v = '0;
        v.acc = 1'b1; v.psel = p; v.step = st; v.ea = ea; v.eb = eb; v.req = r;
        return v;
    endfunction

    function automatic vec_t vd(logic [4:0] o, logic [15:0] ea, logic [3:0] eb,
                                logic [7:0] r);
        vec_t v = '0;
        v.acc = 1'b1; v.dir = 1'b1; v.psel = 2'd0; v.step = 3'd1;
        v.off = o; v.ea = ea; v.eb = eb; v.req = r;
        return v;
    endfunction

    function automatic vec_t vwa(logic [3:0] s, logic [15:0] d, logic [1:0] p,
                                 logic [2:0] st, logic [15:0] ea, logic [3:0] eb,
                                 logic [7:0] r);
        vec_t v = va(p, st, ea, eb, r);
        v.wr = 1'b1; v.wsel = s; v.wdata = d;
        return v;
    endfunction

    localparam int NV = 43;
    localparam vec_t VECS [NV] = '{
        va(0, 0, 16'h0000, 4'b0001, 1),      // R1 pointer 0 reset value
        vw(0, 16'h0100, 2),                  // R2 load pointer 0
        va(0, 1, 16'h0100, 4'b0001, 4),      // R4 +1
        va(0, 0, 16'h0101, 4'b0001, 4),
        va(0, 2, 16'h0101, 4'b0001, 4),      // R4 -1
        va(0, 3, 16'h0100, 4'b0001, 4),      // R4 +2
        va(0, 0, 16'h0102, 4'b0001, 3),      // R3 pre-modify address
        vw(6, 16'hFFFD, 5),                  // R5 increment A = -3
        vw(7, 16'h0010, 5),                  // R5 increment B = +16
        vw(1, 16'h0900, 2),
        va(1, 4, 16'h0900, 4'b0010, 5),
        va(1, 5, 16'h08FD, 4'b0010, 5),
        va(1, 0, 16'h090D, 4'b0010, 5),
        vw(4, 16'h1000, 6),                  // R6 first
        vw(5, 16'h1002, 6),                  // R6 last
        vw(2, 16'h1001, 6),
        va(2, 1, 16'h1001, 4'b0100, 6),
        va(2, 1, 16'h1002, 4'b0100, 6),      // wrap
        va(2, 3, 16'h1000, 4'b0100, 6),
        va(2, 3, 16'h1002, 4'b0100, 6),      // wrap with +2
        va(2, 0, 16'h1000, 4'b0100, 6),
        vw(5, 16'h0000, 7),                  // R7 last cleared
        vw(3, 16'hFFFF, 7),
        va(3, 1, 16'hFFFF, 4'b0000, 9),      // R9 unmapped
        va(3, 1, 16'h0000, 4'b0001, 7),      // R7 ptr==last==0, no wrap
        va(3, 0, 16'h0001, 4'b0001, 7),
        vw(8, 16'h1ABC, 8),                  // R8 base
        vd(5'h1F, 16'h1ABF, 4'b1000, 8),
        va(0, 0, 16'h0102, 4'b0001, 8),      // R8 pointer 0 untouched
        vw(8, 16'h2000, 9),
        vd(5'h00, 16'h2000, 4'b0000, 9),     // R9 direct unmapped
        vwa(0, 16'h0500, 0, 1, 16'h0102, 4'b0001, 10), // R10 collide
        va(0, 0, 16'h0500, 4'b0001, 10),
        va(0, 6, 16'h0500, 4'b0001, 10),
        va(0, 7, 16'h0500, 4'b0001, 10),
        va(0, 0, 16'h0500, 4'b0001, 10),
        vw(9, 16'h7777, 11),                 // R11 unused select
        vw(15, 16'h7777, 11),
        va(1, 0, 16'h090D, 4'b0010, 11),
        va(2, 0, 16'h1000, 4'b0100, 11),
        va(3, 4, 16'h0001, 4'b0001, 11),
        va(3, 0, 16'hFFFE, 4'b0000, 11),
        vd(5'h00, 16'h2000, 4'b0000, 11)
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [15:0] wr_data;
    logic        acc_en;
    logic        acc_direct;
    logic [1:0]  ptr_sel;
    logic [2:0]  step_sel;
    logic [4:0]  dir_off;
    logic [15:0] addr_out;
    logic [3:0]  bank_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dag_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .acc_en     (acc_en),
        .acc_direct (acc_direct),
        .ptr_sel    (ptr_sel),
        .step_sel   (step_sel),
        .dir_off    (dir_off),
        .addr_out   (addr_out),
        .bank_en    (bank_en)
    );

    task automatic apply(input vec_t v);
        wr_en = v.wr; wr_sel = v.wsel; wr_data = v.wdata;
        acc_en = v.acc; acc_direct = v.dir; ptr_sel = v.psel;
        step_sel = v.step; dir_off = v.off;
    endtask

    task automatic check(input vec_t v, input int idx);
        n_cmp++;
        if (addr_out !== v.ea || bank_en !== v.eb) begin
            n_bad++;
            $display("FAIL R%0d vec %0d: addr=%h bank=%b expected addr=%h bank=%b",
                     v.req, idx, addr_out, bank_en, v.ea, v.eb);
        end
    endtask

    task automatic step_vec(input vec_t v, input int idx);
        @(negedge clk);
        apply(v);
        #1;
        check(v, idx);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        apply('0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) step_vec(VECS[i], i);

        // R1: reset mid-run clears pointers and base
        @(negedge clk);
        apply('0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step_vec(va(1, 0, 16'h0000, 4'b0001, 1), 100);
        step_vec(va(2, 0, 16'h0000, 4'b0001, 1), 101);
        step_vec(vd(5'h05, 16'h0005, 4'b0001, 1), 102);
        // R1: increment A cleared, step adds zero
        step_vec(va(0, 4, 16'h0000, 4'b0001, 1), 103);
        step_vec(va(0, 0, 16'h0000, 4'b0001, 1), 104);

        @(negedge clk);
        apply('0);
        #1;
        step_vec('0, 105);  // R3/R9 idle cycle: zero address, no enable

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule